// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter for operating-system time slicing. Software programs a reload value, selects a tick source and starts the counter through four word-wide registers. The counter moves one step on every enabled tick. The tick is either every core clock cycle or a single-cycle reference strobe that is synchronous to the core clock. On expiry the counter reloads, raises a sticky flag and, if interrupts are enabled, drives a one-clock interrupt pulse.

Software can poll the sticky flag, which clears when the control register is read. Software can restart the current period by writing anything to the current-value register. A zero reload value gives a one-shot: the timer switches itself off after a single expiry.

Register offsets: control/status at 0x0, reload at 0x4, current value at 0x8, calibration at 0xC.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers read 0 and `irq_o` is low.
- R2: A write to control (offset 0x0) stores only data bits 2:0: bit 0 run, bit 1 interrupt enable, bit 2 tick source. The flag at bit 16 and every other bit ignore the written data. A control read returns those three bits, the flag at bit 16, and zeros elsewhere.
- R3: A control read returns the current flag value and clears the flag at the end of that same access, unless an expiry occurs in that cycle.
- R4: When run changes from 0 to 1, the first tick loads the counter from the reload value. Each later tick decrements it. A tick that finds the count at 0 is an expiry and reloads, so one period is reload+1 ticks.
- R5: With tick source 1 the counter ticks on every core clock. With tick source 0 it ticks only in cycles where `ref_tick_i` is high, and otherwise holds.
- R6: An expiry sets the flag. If interrupt enable is 1, `irq_o` is high for exactly the one clock after the expiry edge. With interrupt enable 0, `irq_o` stays low.
- R7: An expiry while the reload value is 0 clears run, so the timer stops after one expiry.
- R8: A write of any data to current value (offset 0x8) loads the counter from the reload value and clears the flag.
- R9: Current value reads 0 while run is 0 or while the start-up load is still pending.
- R10: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC, including unaligned ones, return 0. Writes to them change nothing.
- R11: Reload and current value are 24 bits wide, and bits 31:24 read as 0. Calibration (offset 0xC) always reads 10000, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Reference tick strobe, one core cycle wide |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the cycle of `bus_rd_i` |
| irq_o | output | 1 | One-clock interrupt pulse on expiry |

## Verification
The counter is driven from the core clock with a non-zero reload. Interrupt pulses are expected on exact edges, which separates a correct reload+1 period from an off-by-one reload or a missing start-up load. A zero reload is run to tell the self-stopping one-shot apart from a free-running counter. Reference-strobe mode is stepped one strobe at a time with long gaps between strobes, so counting on idle clocks shows up at once. Flag handling is tried three ways: cleared by a control read, cleared by a current-value write, and preserved through a control write.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types for the system tick timer.
// Assumes a byte-addressed, word-wide register port.
package tick_timer_pkg;

    localparam int CNT_W       = 24;
    localparam int OFS_CTRL    = 'h0;
    localparam int OFS_RELOAD  = 'h4;
    localparam int OFS_CURRENT = 'h8;
    localparam int OFS_CALIB   = 'hC;
    localparam int BIT_FLAG    = 16;

    // Writable control bits, MSB first: tick source, interrupt enable, run
    typedef struct packed {
        logic use_core;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CURRENT,
        SEL_CALIB
    } reg_sel_e;

endpackage

// File: rtl/tick_source_sel.sv
// Picks the counting strobe: every core clock or the reference strobe.
// Assumes ref_tick_i is already synchronous to the core clock.
module tick_source_sel (
    input  logic run_i,
    input  logic use_core_i,
    input  logic ref_tick_i,
    output logic tick_o
);

    // Gate the chosen strobe with the run bit
    always_comb begin
        tick_o = run_i && (use_core_i || ref_tick_i);
    end

endmodule

// File: rtl/tick_ctrl_regs.sv
// Holds the control bits, sticky flag and reload value.
// Assumes the counter never signals expiry in a cycle with a current write.
module tick_ctrl_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              rd_ctrl_i,
    input  logic              wr_reload_i,
    input  logic              wr_cur_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expire_i,
    input  logic              autostop_i,
    output ctrl_t             ctrl_o,
    output logic              flag_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              arm_o
);

    ctrl_t             ctrl_q;
    logic              flag_q;
    logic [CNT_W-1:0]  reload_q;

    // Control bits: software write, then self-stop overrides run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i[2:0]);
            if (autostop_i) ctrl_q.run <= 1'b0;
        end
    end

    // Sticky flag: expiry sets, control read or current write clears
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= 1'b0;
        else if (expire_i)                flag_q <= 1'b1;
        else if (rd_ctrl_i || wr_cur_i)   flag_q <= 1'b0;
    end

    // Reload value storage, low 24 bits of the write data
    always_ff @(posedge clk) begin
        if (!rst_n)           reload_q <= '0;
        else if (wr_reload_i) reload_q <= wdata_i[CNT_W-1:0];
    end

    // Start request on a 0-to-1 change of the run bit
    always_comb begin
        arm_o = wr_ctrl_i && wdata_i[0] && !ctrl_q.run;
    end

    assign ctrl_o   = ctrl_q;
    assign flag_o   = flag_q;
    assign reload_o = reload_q;

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_o);
    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl_i && !expire_i) |=> !flag_o);
    p_cur_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur_i |=> !flag_o);
    p_autostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        autostop_i |=> !ctrl_o.run);
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !autostop_i) |=> (ctrl_o == ctrl_t'($past(wdata_i[2:0]))));
    p_flag_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !expire_i && !rd_ctrl_i && !wr_cur_i) |=> $stable(flag_o));

endmodule

// File: rtl/tick_downcounter.sv
// 24-bit down-counter with a pending start-up load and expiry detection.
// Assumes force_load_i and arm_i never arrive in the same cycle.
module tick_downcounter
    import tick_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic             force_load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pending_o,
    output logic             expire_o,
    output logic             autostop_o
);

    logic [CNT_W-1:0] count_q;
    logic             pending_q;

    // Expiry: a tick that finds zero with no load waiting or forced
    always_comb begin
        expire_o   = tick_i && !pending_q && (count_q == '0) && !force_load_i;
        autostop_o = expire_o && (reload_i == '0);
    end

    // Count state: forced load, arming, then tick-driven stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            pending_q <= 1'b0;
        end else if (force_load_i) begin
            count_q   <= reload_i;
            pending_q <= 1'b0;
        end else if (arm_i) begin
            pending_q <= 1'b1;
        end else if (tick_i) begin
            if (pending_q || count_q == '0) begin
                count_q   <= reload_i;
                pending_q <= 1'b0;
            end else begin
                count_q   <= count_q - 1'b1;
            end
        end
    end

    assign count_o   = count_q;
    assign pending_o = pending_q;

    p_force_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_load_i |=> (count_o == $past(reload_i)) && !pending_o);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !force_load_i && !arm_i) |=> $stable(count_o) && $stable(pending_o));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !pending_o && count_o != '0 && !force_load_i && !arm_i)
            |=> (count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/sys_tick_timer.sv
// System tick timer top: register decode, read mux and interrupt pulse.
// Assumes full-word accesses and at most one of read or write per cycle.
module sys_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    reg_sel_e          sel;
    ctrl_t             ctrl;
    logic              flag;
    logic [CNT_W-1:0]  reload;
    logic [CNT_W-1:0]  count;
    logic              pending;
    logic              arm;
    logic              tick;
    logic              expire;
    logic              autostop;
    logic              irq_q;
    logic              wr_ctrl, rd_ctrl, wr_reload, wr_cur;

    // Address decode of the four word registers
    always_comb begin
        if      (bus_addr_i == ADDR_W'(OFS_CTRL))    sel = SEL_CTRL;
        else if (bus_addr_i == ADDR_W'(OFS_RELOAD))  sel = SEL_RELOAD;
        else if (bus_addr_i == ADDR_W'(OFS_CURRENT)) sel = SEL_CURRENT;
        else if (bus_addr_i == ADDR_W'(OFS_CALIB))   sel = SEL_CALIB;
        else                                         sel = SEL_NONE;
    end

    // Per-register access strobes
    always_comb begin
        wr_ctrl   = bus_wr_i && (sel == SEL_CTRL);
        rd_ctrl   = bus_rd_i && (sel == SEL_CTRL);
        wr_reload = bus_wr_i && (sel == SEL_RELOAD);
        wr_cur    = bus_wr_i && (sel == SEL_CURRENT);
    end

    tick_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_ctrl),
        .rd_ctrl_i   (rd_ctrl),
        .wr_reload_i (wr_reload),
        .wr_cur_i    (wr_cur),
        .wdata_i     (bus_wdata_i),
        .expire_i    (expire),
        .autostop_i  (autostop),
        .ctrl_o      (ctrl),
        .flag_o      (flag),
        .reload_o    (reload),
        .arm_o       (arm)
    );

    tick_source_sel u_src (
        .run_i      (ctrl.run),
        .use_core_i (ctrl.use_core),
        .ref_tick_i (ref_tick_i),
        .tick_o     (tick)
    );

    tick_downcounter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .arm_i        (arm),
        .force_load_i (wr_cur),
        .reload_i     (reload),
        .count_o      (count),
        .pending_o    (pending),
        .expire_o     (expire),
        .autostop_o   (autostop)
    );

    // Read data mux, zero when idle or at an undefined offset
    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (sel)
                SEL_CTRL: begin
                    bus_rdata_o[2:0]      = ctrl;
                    bus_rdata_o[BIT_FLAG] = flag;
                end
                SEL_RELOAD:  bus_rdata_o = DATA_W'(reload);
                SEL_CURRENT: bus_rdata_o = (ctrl.run && !pending) ? DATA_W'(count) : '0;
                SEL_CALIB:   bus_rdata_o = DATA_W'(CAL_VALUE);
                default:     bus_rdata_o = '0;
            endcase
        end
    end

    // One-clock interrupt pulse after an expiry with interrupts enabled
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && ctrl.irq_en;
    end

    assign irq_o = irq_q;

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.irq_en) |=> irq_o);
    p_idle_no_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !expire);

endmodule

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_RLD  = 8'h04;
    localparam logic [7:0] A_CUR  = 8'h08;
    localparam logic [7:0] A_CAL  = 8'h0C;

    always #2.5 clk = ~clk;

    sys_tick_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick_i  (ref_tick),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    // Driver: queue the expected read data, then issue the read
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd = 1'b1; addr = a;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic ref_pulse();
        @(posedge clk); #1;
        ref_tick = 1'b1;
        @(posedge clk); #1;
        ref_tick = 1'b0;
    endtask

    // Monitor: compare read data against the scoreboard mid-cycle
    always @(negedge clk) begin
        if (rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: unexpected read, got %h expected none", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(A_CTRL, 32'h0, "R1 ctrl");
        bus_read(A_RLD,  32'h0, "R1 reload");
        bus_read(A_CUR,  32'h0, "R1 current");

        // R11: width and calibration
        bus_write(A_RLD, 32'hFFFF_FFFF);
        bus_read(A_RLD, 32'h00FF_FFFF, "R11 reload upper bits");
        bus_read(A_CAL, 32'd10000, "R11 calib");
        bus_write(A_CAL, 32'h0);
        bus_read(A_CAL, 32'd10000, "R11 calib after write");

        // R10: undefined offsets
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'h0000_0123);
        bus_read(8'h10, 32'h0, "R10 read 0x10");
        bus_read(8'h05, 32'h0, "R10 read 0x05");
        bus_read(A_RLD, 32'h00FF_FFFF, "R10 reload untouched");
        bus_read(A_CTRL, 32'h0, "R10 ctrl untouched");

        // R5, R9, R8: reference-strobe stepping
        bus_write(A_RLD, 32'd5);
        bus_write(A_CTRL, 32'h1);
        bus_read(A_CUR, 32'h0, "R9 load pending");
        ref_pulse();
        bus_read(A_CUR, 32'd5, "R4 first tick loads");
        ref_pulse();
        ref_pulse();
        bus_read(A_CUR, 32'd3, "R5 two strobes");
        repeat (10) @(posedge clk);
        bus_read(A_CUR, 32'd3, "R5 holds without strobe");
        bus_write(A_RLD, 32'd9);
        bus_write(A_CUR, 32'h1234_5678);
        bus_read(A_CUR, 32'd9, "R8 current write reloads");
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CUR, 32'h0, "R9 disabled");
        bus_write(A_CTRL, 32'h1);
        bus_read(A_CUR, 32'h0, "R9 re-enable pending");
        ref_pulse();
        bus_read(A_CUR, 32'd9, "R4 re-enable loads");
        bus_write(A_CTRL, 32'h0);

        // R4, R6: core-clock period of reload+1 with interrupts
        bus_write(A_RLD, 32'd3);
        bus_write(A_CTRL, 32'h7);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk($sformatf("R4 R6 irq at edge %0d", k), {31'b0, irq},
                {31'b0, (k == 5 || k == 9)});
        end
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, 32'h0001_0000, "R6 flag set");
        bus_read(A_CTRL, 32'h0, "R3 flag cleared by read");

        // R6: no interrupt when interrupt enable is 0
        bus_write(A_RLD, 32'd1);
        bus_write(A_CTRL, 32'h5);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk($sformatf("R6 irq masked %0d", k), {31'b0, irq}, 32'h0);
        end
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, 32'h0001_0000, "R6 flag without irq");

        // R7: zero reload stops after one expiry
        bus_write(A_RLD, 32'd0);
        bus_write(A_CTRL, 32'h7);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk($sformatf("R7 irq at edge %0d", k), {31'b0, irq}, {31'b0, (k == 2)});
        end
        bus_read(A_CTRL, 32'h0001_0006, "R7 run cleared, flag set");
        bus_read(A_CTRL, 32'h0000_0006, "R3 second read");
        bus_read(A_CUR, 32'h0, "R9 after self-stop");

        // R8: current write clears the flag
        bus_write(A_CTRL, 32'h7);
        repeat (4) @(posedge clk);
        bus_write(A_CUR, 32'hDEAD);
        bus_read(A_CTRL, 32'h0000_0006, "R8 flag cleared by current write");

        // R2: control write keeps the flag and ignores upper bits
        bus_write(A_CTRL, 32'h7);
        repeat (4) @(posedge clk);
        bus_write(A_CTRL, 32'hFFFE_FFFA);
        bus_read(A_CTRL, 32'h0001_0002, "R2 masked write keeps flag");
        bus_read(A_CTRL, 32'h0000_0002, "R2 readback");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule